// File: doc/BRIEF.md
# Software-Loaded Translation Buffer

This block is a 32-entry address translation buffer that software fills one entry at a time. Software first picks a target slot by writing a control word, then writes a virtual-page word and an attribute word into staging registers. A final write of the physical-page word commits one entry. That entry is built from the physical-page word plus the current contents of both staging registers. A separate current-ASID register names the address space that lookups belong to.

The lookup side is purely combinational. An address is compared against every valid entry whose ASID equals the current ASID. Only the page-number bits above the entry's page size take part in the compare. The block returns the translated physical address, the protection group and the guarded flag, or a miss. Entries may be 4 KB, 16 KB, 512 KB or 8 MB pages. After each commit the slot pointer advances by itself. Software may also keep the top few slots out of that rotation.

Top module: `soft_tlb`

## Requirements
- R1: After reset every entry is invalid, so every lookup misses, and the slot pointer `ctl_idx` is 0.
- R2: A write with `wr_sel`=0 loads the slot pointer from `wr_data[12:8]` and the reserve flag from `wr_data[31]`.
- R3: A write with `wr_sel`=3 commits one entry at the slot pointer. The virtual page comes from staged `[31:12]`, the entry-valid bit from staged bit 9 and the ASID from staged `[3:0]`, all written with `wr_sel`=1. The protection group comes from staged `[8:5]`, guarded from bit 4, size from `[3:2]` and the attribute-valid bit from bit 0, all written with `wr_sel`=2. The physical page comes from the committing word's `[31:12]`. Writes to the staging registers alone change no lookup result. Select codes 5 to 7 have no effect.
- R4: With the reserve flag clear, each commit advances the slot pointer by one, and slot 31 wraps to 0.
- R5: With the reserve flag set, the 4 top slots (28 to 31) are left out of the rotation. A commit at slot 27 or above moves the pointer to 0.
- R6: An entry hits only if both its entry-valid and attribute-valid bits were 1 and its ASID equals the current ASID. The current ASID is set by a `wr_sel`=4 write of `wr_data[3:0]` and is 0 after reset.
- R7: The size code decides how many address bits are compared. Code 11 means 8 MB and compares bits [31:23]. Code 01 means 512 KB and compares bits [31:19]. Code 00 uses bit 3 of the committing physical-page word: 0 gives 4 KB and compares [31:12], 1 gives 16 KB and compares [31:14]. On a hit, `lk_paddr` takes the stored physical page above that boundary and `lk_addr` below it.
- R8: When several entries hit, the lowest-numbered entry supplies the result.
- R9: On a hit, `lk_grp` and `lk_guard` give the winning entry's group and guarded bit. On a miss, `lk_paddr`, `lk_grp` and `lk_guard` are all zero.
- R10: Size code 10 behaves exactly like code 00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select: 0 control, 1 virtual page, 2 attributes, 3 physical page (commit), 4 current ASID |
| wr_data | input | 32 | Write data |
| lk_addr | input | 32 | Lookup address |
| lk_hit | output | 1 | Lookup hit |
| lk_paddr | output | 32 | Translated address, zero on miss |
| lk_grp | output | 4 | Protection group of the winning entry |
| lk_guard | output | 1 | Guarded flag of the winning entry |
| ctl_idx | output | 5 | Slot the next commit loads |

## Verification
The bench builds the block with its default 32 slots and 4 reserved slots. At that size a full trip of the slot pointer takes only 32 commits, and the wrap from slot 27 under the reserve flag takes only a few. Directed cases place overlapping mappings of different page sizes at chosen slots to exercise priority and the boundary of each compare. A long random phase follows, in which lookup addresses are aimed at stored pages so that hits, ASID misses and size masking all occur often.

// File: rtl/soft_tlb.sv
module soft_tlb #(
  parameter int N_ENT   = 32,
  parameter int RSV_CNT = 4,
  localparam int IW     = $clog2(N_ENT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_sel,
  input  logic [31:0]   wr_data,
  input  logic [31:0]   lk_addr,
  output logic          lk_hit,
  output logic [31:0]   lk_paddr,
  output logic [3:0]    lk_grp,
  output logic          lk_guard,
  output logic [IW-1:0] ctl_idx
);
  localparam int LIM = N_ENT - RSV_CNT;

  logic          rsv;
  logic [3:0]    cur_asid;
  logic [19:0]   ep_vpn;
  logic          ep_v, at_v, at_gd;
  logic [3:0]    ep_asid, at_grp;
  logic [1:0]    at_sz;

  logic [N_ENT-1:0] vld;
  logic [19:0]   e_vpn  [N_ENT];
  logic [19:0]   e_ppn  [N_ENT];
  logic [3:0]    e_asid [N_ENT];
  logic [3:0]    e_grp  [N_ENT];
  logic          e_gd   [N_ENT];
  logic [1:0]    e_sz   [N_ENT];

  wire commit = wr_en && wr_sel == 3'd3;
  wire unused_bits = ^{wr_data[11:10], wr_data[1]};

  // internal size code: 3 = 8M, 2 = 512K, 1 = 16K, 0 = 4K
  wire [1:0] new_sz = (at_sz == 2'b11) ? 2'd3 :
                      (at_sz == 2'b01) ? 2'd2 :
                      (wr_data[3] ? 2'd1 : 2'd0);

  wire [IW-1:0] idx_nxt = (rsv && int'(ctl_idx) >= LIM - 1) ? '0 :
                          (int'(ctl_idx) == N_ENT - 1) ? '0 : ctl_idx + 1'b1;

  function automatic logic [19:0] pmask(input logic [1:0] s);
    case (s)
      2'd3:    pmask = 20'hFF800;
      2'd2:    pmask = 20'hFFF80;
      2'd1:    pmask = 20'hFFFFC;
      default: pmask = 20'hFFFFF;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_idx  <= '0;
      rsv      <= 1'b0;
      cur_asid <= '0;
      ep_vpn <= '0; ep_v <= 1'b0; ep_asid <= '0;
      at_grp <= '0; at_gd <= 1'b0; at_sz <= '0; at_v <= 1'b0;
      vld <= '0;
    end else if (wr_en) begin
      case (wr_sel)
        3'd0: begin ctl_idx <= wr_data[8 +: IW]; rsv <= wr_data[31]; end
        3'd1: begin ep_vpn <= wr_data[31:12]; ep_v <= wr_data[9]; ep_asid <= wr_data[3:0]; end
        3'd2: begin at_grp <= wr_data[8:5]; at_gd <= wr_data[4]; at_sz <= wr_data[3:2]; at_v <= wr_data[0]; end
        3'd3: begin vld[ctl_idx] <= ep_v & at_v; ctl_idx <= idx_nxt; end
        3'd4: cur_asid <= wr_data[3:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (commit) begin
      e_vpn[ctl_idx]  <= ep_vpn;
      e_ppn[ctl_idx]  <= wr_data[31:12];
      e_asid[ctl_idx] <= ep_asid;
      e_grp[ctl_idx]  <= at_grp;
      e_gd[ctl_idx]   <= at_gd;
      e_sz[ctl_idx]   <= new_sz;
    end
  end

  logic [N_ENT-1:0] match;
  for (genvar g = 0; g < N_ENT; g++) begin : g_cmp
    assign match[g] = vld[g] && e_asid[g] == cur_asid &&
                      ((e_vpn[g] ^ lk_addr[31:12]) & pmask(e_sz[g])) == 20'd0;
  end

  logic [IW-1:0] win;
  always_comb begin
    win = '0;
    for (int i = N_ENT - 1; i >= 0; i--)
      if (match[i]) win = IW'(i);
  end

  wire [19:0] wm = pmask(e_sz[win]);
  assign lk_hit   = |match;
  assign lk_paddr = lk_hit ? {(e_ppn[win] & wm) | (lk_addr[31:12] & ~wm), lk_addr[11:0]} : 32'd0;
  assign lk_grp   = lk_hit ? e_grp[win] : 4'd0;
  assign lk_guard = lk_hit & e_gd[win];

  // R2
  ctl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 3'd0) |=> ctl_idx == $past(wr_data[8 +: IW]));
  // R3
  commit_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> vld[$past(ctl_idx)] == $past(ep_v & at_v));
  // R4
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !rsv && int'(ctl_idx) < N_ENT - 1) |=> ctl_idx == $past(ctl_idx) + 1'b1);
  // R5
  rsv_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && rsv && int'(ctl_idx) >= LIM - 1) |=> ctl_idx == '0);
  // R9
  miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_paddr == 32'd0 && lk_grp == 4'd0 && !lk_guard));
endmodule

// File: tb/sim_soft_tlb.sv
`timescale 1ns/1ps
module sim_soft_tlb;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [2:0] wr_sel = '0;
  logic [31:0] wr_data = '0, lk_addr = '0;
  logic lk_hit, lk_guard;
  logic [31:0] lk_paddr;
  logic [3:0] lk_grp;
  logic [4:0] ctl_idx;

  soft_tlb u0 (.clk, .rst_n, .wr_en, .wr_sel, .wr_data, .lk_addr,
               .lk_hit, .lk_paddr, .lk_grp, .lk_guard, .ctl_idx);

  always #10 clk = ~clk;

  int tests = 0, fails = 0;
  bit done = 0;

  int m_idx, m_rsv, m_cur;
  logic [31:0] m_ep, m_at;
  bit m_v [32];
  logic [31:0] m_vpn [32], m_ppn [32];
  int m_asid [32], m_grp [32], m_gd [32], m_sh [32];

  function automatic void mreset();
    m_idx = 0; m_rsv = 0; m_cur = 0; m_ep = 0; m_at = 0;
    for (int i = 0; i < 32; i++) begin
      m_v[i] = 0; m_vpn[i] = 0; m_ppn[i] = 0; m_asid[i] = 0;
      m_grp[i] = 0; m_gd[i] = 0; m_sh[i] = 12;
    end
  endfunction

  function automatic void mwrite(input logic [2:0] s, input logic [31:0] d);
    case (s)
      3'd0: begin m_idx = int'(d[12:8]); m_rsv = int'(d[31]); end
      3'd1: m_ep = d;
      3'd2: m_at = d;
      3'd3: begin
        m_v[m_idx]    = m_ep[9] & m_at[0];
        m_vpn[m_idx]  = {m_ep[31:12], 12'h0};
        m_asid[m_idx] = int'(m_ep[3:0]);
        m_grp[m_idx]  = int'(m_at[8:5]);
        m_gd[m_idx]   = int'(m_at[4]);
        m_sh[m_idx]   = (m_at[3:2] == 2'b11) ? 23 : (m_at[3:2] == 2'b01) ? 19 : (d[3] ? 14 : 12);
        m_ppn[m_idx]  = {d[31:12], 12'h0};
        if (m_rsv != 0 && m_idx >= 27) m_idx = 0;
        else m_idx = (m_idx + 1) % 32;
      end
      3'd4: m_cur = int'(d[3:0]);
      default: ;
    endcase
  endfunction

  task automatic check(input string tag);
    logic eh; logic [31:0] ep; int eg, ed;
    eh = 0; ep = 0; eg = 0; ed = 0;
    for (int i = 0; i < 32; i++) begin
      if (!eh && m_v[i] && m_asid[i] == m_cur &&
          (lk_addr >> m_sh[i]) == (m_vpn[i] >> m_sh[i])) begin
        eh = 1;
        ep = ((m_ppn[i] >> m_sh[i]) << m_sh[i]) | (lk_addr & ((32'd1 << m_sh[i]) - 1));
        eg = m_grp[i]; ed = m_gd[i];
      end
    end
    tests++;
    if (lk_hit !== eh || lk_paddr !== ep || int'(lk_grp) != eg || int'(lk_guard) != ed ||
        int'(ctl_idx) != m_idx) begin
      fails++;
      $display("FAIL %s hit=%0b/%0b paddr=%h/%h grp=%0d/%0d guard=%0d/%0d idx=%0d/%0d",
               tag, lk_hit, eh, lk_paddr, ep, lk_grp, eg, lk_guard, ed, ctl_idx, m_idx);
    end
  endtask

  task automatic cyc(input logic we, input logic [2:0] s, input logic [31:0] d,
                     input logic [31:0] a, input string tag);
    wr_en = we; wr_sel = s; wr_data = d; lk_addr = a;
    @(negedge clk);
    if (we) mwrite(s, d);
    check(tag);
  endtask

  task automatic load(input int idx, input logic [31:0] ep, input logic [31:0] at,
                      input logic [31:0] rp, input string tag);
    if (idx >= 0) cyc(1, 3'd0, {m_rsv[0], 18'd0, 5'(idx), 8'd0}, lk_addr, tag);
    cyc(1, 3'd1, ep, lk_addr, tag);
    cyc(1, 3'd2, at, lk_addr, tag);
    cyc(1, 3'd3, rp, lk_addr, tag);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    mreset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: empty after reset
    cyc(0, 3'd0, 0, 32'h0000_0000, "R1");
    cyc(0, 3'd0, 0, 32'h1234_5ABC, "R1");
    // R6: current ASID
    cyc(1, 3'd4, 32'h5, 32'h1234_5ABC, "R6");
    // R3: staging alone has no effect
    cyc(1, 3'd1, 32'h1234_5205, 32'h1234_5ABC, "R3");
    cyc(1, 3'd2, 32'h0000_0071, 32'h1234_5ABC, "R3");
    cyc(1, 3'd5, 32'hFFFF_FFFF, 32'h1234_5ABC, "R3");
    cyc(1, 3'd3, 32'hABCD_E000, 32'h1234_5ABC, "R3");
    cyc(0, 3'd0, 0, 32'h1234_5FFF, "R7");
    cyc(0, 3'd0, 0, 32'h1234_6000, "R7");
    // R6: ASID mismatch
    cyc(1, 3'd4, 32'h6, 32'h1234_5ABC, "R6");
    cyc(1, 3'd4, 32'h5, 32'h1234_5ABC, "R6");
    // R7: 16K page at slot 1
    load(-1, 32'h2000_4205, 32'h0000_0021, 32'h5555_0008, "R7");
    cyc(0, 3'd0, 0, 32'h2000_7123, "R7");
    cyc(0, 3'd0, 0, 32'h2000_8123, "R7");
    // R7: 512K and 8M
    load(-1, 32'h3008_0205, 32'h0000_0005, 32'h7000_0000, "R7");
    cyc(0, 3'd0, 0, 32'h300F_F123, "R7");
    cyc(0, 3'd0, 0, 32'h3010_0000, "R7");
    load(-1, 32'h6000_0205, 32'h0000_008D, 32'h0880_0000, "R7");
    cyc(0, 3'd0, 0, 32'h607F_FFFF, "R9");
    cyc(0, 3'd0, 0, 32'h6080_0000, "R9");
    // R10: size code 10 acts as small, 16K via bit 3
    load(-1, 32'h7000_0205, 32'h0000_0009, 32'h1111_1008, "R10");
    cyc(0, 3'd0, 0, 32'h7000_3456, "R10");
    cyc(0, 3'd0, 0, 32'h7000_4456, "R10");
    // R8: priority of lower slot
    load(20, 32'h4000_0205, 32'h0000_002D, 32'h0A00_0000, "R8");
    load(10, 32'h4000_1205, 32'h0000_0041, 32'h0B00_0000, "R8");
    cyc(0, 3'd0, 0, 32'h4000_1234, "R8");
    cyc(0, 3'd0, 0, 32'h4000_2234, "R8");
    // R6: invalid bits
    load(12, 32'h4800_0005, 32'h0000_0001, 32'h0C00_0000, "R6");
    load(13, 32'h4900_0205, 32'h0000_0000, 32'h0D00_0000, "R6");
    cyc(0, 3'd0, 0, 32'h4800_0000, "R6");
    cyc(0, 3'd0, 0, 32'h4900_0000, "R6");
    // R2 / R4: wrap at top
    cyc(1, 3'd0, 32'h0000_1F00, 32'h0, "R2");
    load(-1, 32'h5000_0205, 32'h0000_0001, 32'h0E00_0000, "R4");
    cyc(0, 3'd0, 0, 32'h5000_0000, "R4");
    // R5: reserve flag
    cyc(1, 3'd0, 32'h8000_1A00, 32'h0, "R5");
    load(-1, 32'h5100_0205, 32'h0000_0001, 32'h0F00_0000, "R5");
    load(-1, 32'h5200_0205, 32'h0000_0001, 32'h0F10_0000, "R5");
    cyc(1, 3'd0, 32'h8000_1E00, 32'h5200_0000, "R5");
    load(-1, 32'h5300_0205, 32'h0000_0001, 32'h0F20_0000, "R5");
    cyc(0, 3'd0, 0, 32'h5300_0000, "R5");
    // random phase
    for (int k = 0; k < 3000; k++) begin
      logic [2:0] s; logic [31:0] d, a; int e;
      s = 3'($urandom_range(0, 5));
      d = $urandom;
      if (s == 3'd1 && k % 2 == 0) d[3:0] = 4'(m_cur);
      if (s == 3'd1 || s == 3'd2) begin d[9] = ($urandom % 4) != 0; d[0] = ($urandom % 4) != 0; end
      if (s == 3'd4) d[3:0] = 4'($urandom_range(0, 3));
      e = $urandom_range(0, 31);
      a = m_vpn[e] ^ ($urandom & ((k % 3 == 0) ? 32'h00FF_FFFF : 32'h0000_3FFF));
      cyc(($urandom % 4) != 0, s, d, a, "R7");
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule